// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block receives asynchronous serial frames on a single line. It works from a clock-rate enable that pulses sixteen times per bit period. A frame is a low start bit, then eight or nine data bits with the least significant bit first, then a high stop bit. The selected width is taken at the start of each frame. When a frame completes, the eight data bits go to a receive buffer. A ninth status bit is also written: the received ninth data bit in nine-bit mode, or the stop-bit level in eight-bit mode. A receive-ready flag is then raised.

A mode-enable input chooses between two ways of handling frames.

- **Legacy handling:** a frame that completes while the ready flag is still set is dropped, and nothing records the loss.
- **Extended handling:** every frame is accepted. The block also keeps three sticky error flags:
  - framing error: the stop bit was sampled low;
  - line break: the line stayed low for longer than one eleven-bit frame;
  - overwrite: a frame replaced data that had not yet been acknowledged.

Software clears the ready flag with its own strobe. A buffer-read strobe clears the overwrite flag. A status-read strobe clears the framing and break flags. If a flag is set and cleared in the same cycle, the set wins.

Top module: `uart_rx_err`

## Requirements
- R1: In eight-bit mode (`nine_bit`=0 at start), a frame 0, D0..D7 (LSB first), stop is decoded into `rx_data`, and `rx_bit9` takes the sampled stop-bit level.
- R2: In nine-bit mode (`nine_bit`=1 at start), D8 follows D7 and is stored in `rx_bit9`, and the stop level is not stored.
- R3: `err_frame` sets when a completed frame has its stop bit sampled low, in both modes, but only while `ext_en`=1. With `ext_en`=0 the flag is unaffected.
- R4: After reset, `ri`, `rx_data`, `rx_bit9` and all three error flags are 0.
- R5: `ri` rises only as the result of an accepted frame.
- R6: `ri` stays set until a cycle with `ri_clr`=1, which clears it.
- R7: With `ext_en`=1, a frame completing while `ri`=1 overwrites `rx_data`/`rx_bit9` and sets `err_over`. `err_over` is cleared by `buf_rd`.
- R8: With `ext_en`=0, a frame completing while `ri`=1 is discarded. `rx_data`, `rx_bit9` and `err_over` do not change.
- R9: A low level that has gone high again by the mid-start sample (8 ticks after the falling edge) starts no frame and changes no output.
- R10: `stat_rd` clears `err_frame` and `err_break` unless a new event sets them in the same cycle.
- R11: With `ext_en`=1, `err_break` sets once the line has been low for more than 176 consecutive ticks (11 bits × 16). A run of exactly 176 low ticks does not set it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial line, idle high |
| tick16 | input | 1 | Oversample enable, 16 pulses per bit |
| nine_bit | input | 1 | 1 selects nine data bits per frame |
| ext_en | input | 1 | 1 enables extended handling and error flags |
| buf_rd | input | 1 | Receive buffer read strobe, clears `err_over` |
| ri_clr | input | 1 | Clears `ri` |
| stat_rd | input | 1 | Status read strobe, clears `err_frame` and `err_break` |
| rx_data | output | 8 | Received data byte |
| rx_bit9 | output | 1 | Ninth data bit or captured stop level |
| ri | output | 1 | Receive-ready flag |
| err_frame | output | 1 | Sticky framing error |
| err_break | output | 1 | Sticky line-break error |
| err_over | output | 1 | Sticky overwrite error |

## Verification
Errors inside the bit-sequencing state show up directly in the output data. An off-by-one in the sample counter or the bit index gives a shifted or rotated `rx_data`, or a wrong `rx_bit9`, within the one frame where it happens. A stale width latch decodes the stop bit as D8, so `err_frame` is wrong at the end of that frame. A wrong break-count threshold is caught at the 176-tick boundary, which separates a nine-bit null frame from a real break: the error appears as `err_break` set one frame too early, or not at all. Flag-priority faults appear one cycle after a strobe, or as a dropped or kept byte on the next frame that arrives while `ri` is set.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int RX_DATA_W = 8;
    localparam int RX_MAX_W  = RX_DATA_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [RX_DATA_W-1:0] data;
        logic                 ninth;
        logic                 stop;
        logic                 mode9;
    } rx_frame_t;

    // Index of the final data bit for the chosen frame width
    function automatic logic [3:0] last_bit_idx(input logic mode9);
        return mode9 ? 4'(RX_DATA_W) : 4'(RX_DATA_W - 1);
    endfunction

    // Total bits of the widest frame: start + data + ninth + stop
    function automatic int wide_frame_bits();
        return RX_MAX_W + 2;
    endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '1;
        end else begin
            pipe <= {pipe[STAGES-2:0], din};
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/rx_break_det.sv
module rx_break_det #(
    parameter int LIMIT = 177
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic line,
    output logic brk_hit
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            brk_hit <= 1'b0;
        end else begin
            brk_hit <= 1'b0;
            if (tick) begin
                if (line) begin
                    low_cnt <= '0;
                end else if (low_cnt != CW'(LIMIT)) begin
                    low_cnt <= low_cnt + 1'b1;
                    if (low_cnt == CW'(LIMIT - 1)) begin
                        brk_hit <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      line,
    input  logic      nine_bit,
    output logic      frm_done,
    output rx_frame_t frm
);
    localparam int OSW  = $clog2(OSR);
    localparam int HALF = OSR / 2;

    rx_state_e            state;
    logic [OSW-1:0]       os_cnt;
    logic [3:0]           bit_idx;
    logic [RX_MAX_W-1:0]  shreg;
    logic                 mode9;
    logic                 line_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            os_cnt    <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            mode9     <= 1'b0;
            line_prev <= 1'b1;
            frm_done  <= 1'b0;
            frm       <= '0;
        end else begin
            frm_done <= 1'b0;
            if (tick) begin
                line_prev <= line;
                unique case (state)
                    ST_IDLE: begin
                        if (line_prev && !line) begin
                            state  <= ST_START;
                            os_cnt <= '0;
                        end
                    end
                    ST_START: begin
                        if (os_cnt == OSW'(HALF - 1)) begin
                            os_cnt <= '0;
                            if (line) begin
                                state <= ST_IDLE;
                            end else begin
                                state   <= ST_DATA;
                                bit_idx <= '0;
                                shreg   <= '0;
                                mode9   <= nine_bit;
                            end
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (os_cnt == OSW'(OSR - 1)) begin
                            os_cnt         <= '0;
                            shreg[bit_idx] <= line;
                            if (bit_idx == last_bit_idx(mode9)) begin
                                state <= ST_STOP;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (os_cnt == OSW'(OSR - 1)) begin
                            os_cnt    <= '0;
                            state     <= ST_IDLE;
                            frm_done  <= 1'b1;
                            frm.data  <= shreg[RX_DATA_W-1:0];
                            frm.ninth <= shreg[RX_DATA_W];
                            frm.stop  <= line;
                            frm.mode9 <= mode9;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_rx_err.sv
module uart_rx_err
    import uart_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rxd,
    input  logic                 tick16,
    input  logic                 nine_bit,
    input  logic                 ext_en,
    input  logic                 buf_rd,
    input  logic                 ri_clr,
    input  logic                 stat_rd,
    output logic [RX_DATA_W-1:0] rx_data,
    output logic                 rx_bit9,
    output logic                 ri,
    output logic                 err_frame,
    output logic                 err_break,
    output logic                 err_over
);
    localparam int BRK_LIMIT = wide_frame_bits() * OSR + 1;

    logic      line_s;
    logic      frm_done;
    rx_frame_t frm;
    logic      brk_hit;
    logic      accept;
    logic      bit9_val;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (line_s)
    );

    rx_frame_fsm #(.OSR(OSR)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick16),
        .line     (line_s),
        .nine_bit (nine_bit),
        .frm_done (frm_done),
        .frm      (frm)
    );

    rx_break_det #(.LIMIT(BRK_LIMIT)) u_brk (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick16),
        .line    (line_s),
        .brk_hit (brk_hit)
    );

    always_comb begin
        accept   = frm_done && (!ri || ext_en);
        bit9_val = frm.mode9 ? frm.ninth : frm.stop;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data   <= '0;
            rx_bit9   <= 1'b0;
            ri        <= 1'b0;
            err_frame <= 1'b0;
            err_break <= 1'b0;
            err_over  <= 1'b0;
        end else begin
            if (ri_clr)  ri       <= 1'b0;
            if (buf_rd)  err_over <= 1'b0;
            if (stat_rd) begin
                err_frame <= 1'b0;
                err_break <= 1'b0;
            end
            if (brk_hit && ext_en) err_break <= 1'b1;
            if (accept) begin
                rx_data <= frm.data;
                rx_bit9 <= bit9_val;
                ri      <= 1'b1;
                if (ri)                 err_over  <= 1'b1;
                if (ext_en && !frm.stop) err_frame <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_rx_err_chk.sv
module uart_rx_err_chk (
    input logic       clk,
    input logic       rst,
    input logic       ext_en,
    input logic       buf_rd,
    input logic       stat_rd,
    input logic       ri,
    input logic       err_over,
    input logic       err_frame,
    input logic       err_break,
    input logic [7:0] rx_data,
    input logic       frm_done,
    input logic       brk_hit
);
    assert_ri_from_frame_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(ri) |-> $past(frm_done));

    assert_over_needs_ext_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(err_over) |-> $past(ext_en && ri));

    assert_over_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (buf_rd && !frm_done) |=> !err_over);

    assert_frame_needs_ext_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(err_frame) |-> $past(ext_en && frm_done));

    assert_data_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !frm_done |=> $stable(rx_data));

    assert_stat_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !frm_done && !brk_hit) |=> (!err_frame && !err_break));

    assert_break_ext_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(err_break) |-> $past(ext_en && brk_hit));
endmodule

bind uart_rx_err uart_rx_err_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ext_en    (ext_en),
    .buf_rd    (buf_rd),
    .stat_rd   (stat_rd),
    .ri        (ri),
    .err_over  (err_over),
    .err_frame (err_frame),
    .err_break (err_break),
    .rx_data   (rx_data),
    .frm_done  (frm_done),
    .brk_hit   (brk_hit)
);

// File: tb/sim_uart_rx_err.sv
module sim_uart_rx_err;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int BIT_CLKS   = 16 * TICK_DIV;
    localparam int WD_CYCLES  = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic       tick16 = 1'b0;
    logic       nine_bit = 1'b0;
    logic       ext_en = 1'b0;
    logic       buf_rd = 1'b0;
    logic       ri_clr = 1'b0;
    logic       stat_rd = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9, ri, err_frame, err_break, err_over;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    int tdiv     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        tdiv   <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        tick16 <= (tdiv == TICK_DIV - 1);
    end

    uart_rx_err u0 (
        .clk(clk), .rst(rst), .rxd(rxd), .tick16(tick16),
        .nine_bit(nine_bit), .ext_en(ext_en), .buf_rd(buf_rd),
        .ri_clr(ri_clr), .stat_rd(stat_rd), .rx_data(rx_data),
        .rx_bit9(rx_bit9), .ri(ri), .err_frame(err_frame),
        .err_break(err_break), .err_over(err_over)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold_line(input logic v, input int clks);
        for (int i = 0; i < clks; i++) begin
            @(negedge clk);
            rxd = v;
        end
    endtask

    task automatic send_frame(input logic [8:0] d, input logic nine, input logic stop);
        @(negedge clk);
        nine_bit = nine;
        hold_line(1'b0, BIT_CLKS);
        for (int b = 0; b < (nine ? 9 : 8); b++) hold_line(d[b], BIT_CLKS);
        hold_line(stop, BIT_CLKS);
        hold_line(1'b1, 2 * BIT_CLKS);
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1'b1;
        @(negedge clk); s = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R4 ri", ri, 0);
        check("R4 data", rx_data, 0);
        check("R4 bit9", rx_bit9, 0);
        check("R4 flags", {err_frame, err_break, err_over}, 0);
    endtask

    task automatic t_legacy_basic;
        ext_en = 1'b0;
        send_frame(9'h0A5, 1'b0, 1'b1);
        check("R1 data", rx_data, 8'hA5);
        check("R1 bit9 stop", rx_bit9, 1);
        check("R5 ri", ri, 1);
    endtask

    task automatic t_legacy_discard;
        send_frame(9'h012, 1'b0, 1'b1);
        check("R8 data kept", rx_data, 8'hA5);
        check("R8 no over", err_over, 0);
        check("R6 ri held", ri, 1);
        pulse(ri_clr);
        check("R6 ri cleared", ri, 0);
    endtask

    task automatic t_legacy_frame;
        send_frame(9'h00F, 1'b0, 1'b0);
        check("R1 data", rx_data, 8'h0F);
        check("R1 bit9 low stop", rx_bit9, 0);
        check("R3 no frame flag w/o ext", err_frame, 0);
        pulse(ri_clr);
    endtask

    task automatic t_nine_bit;
        ext_en = 1'b1;
        send_frame(9'h13C, 1'b1, 1'b1);
        check("R2 data", rx_data, 8'h3C);
        check("R2 d8", rx_bit9, 1);
        check("R3 good stop", err_frame, 0);
        pulse(ri_clr);
        send_frame(9'h0C3, 1'b1, 1'b0);
        check("R2 data", rx_data, 8'hC3);
        check("R2 d8 not stop", rx_bit9, 0);
        check("R3 frame err 9b", err_frame, 1);
        pulse(stat_rd);
        check("R10 frame cleared", err_frame, 0);
    endtask

    task automatic t_overwrite;
        send_frame(9'h055, 1'b0, 1'b1);
        check("R7 data replaced", rx_data, 8'h55);
        check("R7 over set", err_over, 1);
        check("R7 ri", ri, 1);
        pulse(buf_rd);
        check("R7 over cleared", err_over, 0);
        pulse(ri_clr);
    endtask

    task automatic t_glitch;
        hold_line(1'b0, 3 * TICK_DIV);
        hold_line(1'b1, 2 * BIT_CLKS);
        check("R9 no ri", ri, 0);
        check("R9 data", rx_data, 8'h55);
        check("R9 no flags", {err_frame, err_break, err_over}, 0);
    endtask

    task automatic t_break;
        send_frame(9'h000, 1'b1, 1'b0);
        check("R11 exact frame no break", err_break, 0);
        check("R3 null frame", err_frame, 1);
        pulse(stat_rd);
        pulse(ri_clr);
        hold_line(1'b0, 12 * BIT_CLKS);
        hold_line(1'b1, 2 * BIT_CLKS);
        check("R11 break set", err_break, 1);
        pulse(stat_rd);
        check("R10 break cleared", err_break, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        t_legacy_basic();
        t_legacy_discard();
        t_legacy_frame();
        t_nine_bit();
        t_overwrite();
        t_glitch();
        t_break();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule